// File: doc/BRIEF.md
# Accumulator Processor with Execute-Accumulator Instruction

This block is a small accumulator processor with separate instruction and data memories. It reads instructions through a read-only fetch port and has no path that writes instruction memory. Data goes through a synchronous data memory port with a read latency of one cycle. The instruction set covers load, add, subtract, store, clear, two sign-tested branches and halt. It also has an execute-accumulator instruction, which feeds the current accumulator value into the decoder in place of a fetched word.

Code cannot modify itself and there are no index registers. The execute-accumulator instruction fills that gap. A program builds an instruction word arithmetically in the accumulator and then runs it. An indirect load, for example, is made by adding a load opcode to a pointer value.

Each ordinary instruction takes a fetch cycle and an execute cycle. An execute-accumulator instruction takes one extra execute cycle. Halt and illegal encodings both stop the core for good, and only reset clears them.

Top module: `acc_core`

## Requirements
- R1: An instruction word is 16 bits: opcode in bits [15:10], memory or branch address in bits [9:0]. Opcodes: HLT=0, ADD=1, SUB=2, STORE=3, CLEAR=4, BLT=5, BGE=6, EXD=7, LD=11. Any other opcode is illegal. ADD 6 therefore encodes as 0x0406.
- R2: LD sets ACC to Mem[a]. ADD sets ACC to ACC+Mem[a]. SUB sets ACC to ACC-Mem[a]. CLEAR sets ACC to 0. All arithmetic wraps modulo 2^16.
- R3: STORE writes ACC to data address a with a write strobe that lasts a single cycle. No other instruction writes data memory.
- R4: EXD decodes the current ACC value as an instruction and executes it. Afterwards the program counter moves as that instruction would have moved it. After EXD, ACC is used as a plain number, so ACC=0x0406 with Mem[6]=1 becomes 0x0407.
- R5: BLT jumps to a when ACC bit 15 is 1. BGE jumps to a when ACC bit 15 is 0. Otherwise both fall through to PC+1, and neither changes ACC.
- R6: An illegal opcode raises fault and keeps it raised until reset. This applies whether the opcode was fetched or reached through EXD. While fault is high, the PC is frozen and no data write occurs.
- R7: HLT raises halted until reset and freezes the PC.
- R8: Every instruction takes 2 cycles (fetch, execute), EXD takes 3, and HLT reaches halted at the end of its execute cycle.
- R9: An EXD whose ACC holds an EXD word re-executes forever. The PC holds and neither halted nor fault is raised.
- R10: While and after synchronous reset, PC is 0, ACC is 0, and halted, fault and the data write strobe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 10 | Instruction fetch address (program counter) |
| imem_data | input | 16 | Instruction word, combinational read of imem_addr |
| dmem_addr | output | 10 | Data memory address |
| dmem_we | output | 1 | Data memory write strobe |
| dmem_wdata | output | 16 | Data memory write data (ACC) |
| dmem_rdata | input | 16 | Data memory read data, one cycle after the address |
| halted | output | 1 | Core stopped by HLT |
| fault | output | 1 | Core stopped by an illegal opcode |

## Verification
Some properties are checked on every cycle. Halted and fault must stay high once raised, and the PC must not move after either. A store strobe must never last two cycles. The first EXD cycle must hold the PC and stay in execute, and sequential instructions and taken branches must move the PC correctly.

Other behaviour only the bench scenarios can show. These include the data values themselves, where EXD is chained with arithmetic to build an indirect load over a pointer table. They also include exact cycle totals, faults on illegal words reached through the accumulator, and the non-terminating EXD-of-EXD case.

// File: rtl/acc_pkg.sv
package acc_pkg;
    localparam int WORD_W = 16;
    localparam int OP_W   = 6;
    localparam int ADDR_W = WORD_W - OP_W;

    localparam logic [OP_W-1:0] OPC_HLT   = 6'd0;
    localparam logic [OP_W-1:0] OPC_ADD   = 6'd1;
    localparam logic [OP_W-1:0] OPC_SUB   = 6'd2;
    localparam logic [OP_W-1:0] OPC_STORE = 6'd3;
    localparam logic [OP_W-1:0] OPC_CLEAR = 6'd4;
    localparam logic [OP_W-1:0] OPC_BLT   = 6'd5;
    localparam logic [OP_W-1:0] OPC_BGE   = 6'd6;
    localparam logic [OP_W-1:0] OPC_EXD   = 6'd7;
    localparam logic [OP_W-1:0] OPC_LD    = 6'd11;

    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,
        ST_EXEC  = 2'd1,
        ST_HALT  = 2'd2,
        ST_FAULT = 2'd3
    } core_state_e;

    typedef struct packed {
        logic              legal;
        logic [OP_W-1:0]   op;
        logic [ADDR_W-1:0] addr;
    } dec_t;

    function automatic logic [WORD_W-1:0] make_word(input logic [OP_W-1:0] op,
                                                    input logic [ADDR_W-1:0] addr);
        return {op, addr};
    endfunction
endpackage

// File: rtl/acc_decode.sv
module acc_decode
    import acc_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output dec_t              dec
);
    always_comb begin
        dec.op   = word[WORD_W-1 -: OP_W];
        dec.addr = word[ADDR_W-1:0];
        case (dec.op)
            OPC_HLT, OPC_ADD, OPC_SUB, OPC_STORE, OPC_CLEAR,
            OPC_BLT, OPC_BGE, OPC_EXD, OPC_LD: dec.legal = 1'b1;
            default:                           dec.legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/acc_exec.sv
module acc_exec
    import acc_pkg::*;
(
    input  dec_t              dec,
    input  logic [WORD_W-1:0] acc,
    input  logic [WORD_W-1:0] rdata,
    output logic [WORD_W-1:0] acc_next,
    output logic              take_branch
);
    always_comb begin
        acc_next    = acc;
        take_branch = 1'b0;
        case (dec.op)
            OPC_LD:    acc_next = rdata;
            OPC_ADD:   acc_next = acc + rdata;
            OPC_SUB:   acc_next = acc - rdata;
            OPC_CLEAR: acc_next = '0;
            OPC_BLT:   take_branch = acc[WORD_W-1];
            OPC_BGE:   take_branch = !acc[WORD_W-1];
            default:   acc_next = acc;
        endcase
    end
endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] imem_addr,
    input  logic [WORD_W-1:0] imem_data,
    output logic [ADDR_W-1:0] dmem_addr,
    output logic              dmem_we,
    output logic [WORD_W-1:0] dmem_wdata,
    input  logic [WORD_W-1:0] dmem_rdata,
    output logic              halted,
    output logic              fault
);
    core_state_e       state;
    logic [ADDR_W-1:0] pc;
    logic [WORD_W-1:0] ir;
    logic [WORD_W-1:0] acc;
    dec_t              dec;
    logic [WORD_W-1:0] acc_next;
    logic              take_branch;
    logic              in_exec;
    logic              is_seq;

    acc_decode u_dec (.word(ir), .dec(dec));

    acc_exec u_exec (
        .dec        (dec),
        .acc        (acc),
        .rdata      (dmem_rdata),
        .acc_next   (acc_next),
        .take_branch(take_branch)
    );

    assign in_exec = (state == ST_EXEC) && dec.legal;
    assign is_seq  = (dec.op == OPC_LD) || (dec.op == OPC_ADD) || (dec.op == OPC_SUB) ||
                     (dec.op == OPC_STORE) || (dec.op == OPC_CLEAR);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_FETCH;
            pc    <= '0;
            ir    <= '0;
            acc   <= '0;
        end else begin
            case (state)
                ST_FETCH: begin
                    ir    <= imem_data;
                    state <= ST_EXEC;
                end
                ST_EXEC: begin
                    if (!dec.legal) begin
                        state <= ST_FAULT;
                    end else if (dec.op == OPC_HLT) begin
                        state <= ST_HALT;
                    end else if (dec.op == OPC_EXD) begin
                        ir <= acc;
                    end else begin
                        acc   <= acc_next;
                        pc    <= take_branch ? dec.addr : pc + ADDR_W'(1);
                        state <= ST_FETCH;
                    end
                end
                default: state <= state;
            endcase
        end
    end

    always_comb begin
        if (state == ST_FETCH)
            dmem_addr = imem_data[ADDR_W-1:0];
        else if (dec.op == OPC_EXD)
            dmem_addr = acc[ADDR_W-1:0];
        else
            dmem_addr = dec.addr;
    end

    assign dmem_we    = in_exec && (dec.op == OPC_STORE);
    assign dmem_wdata = acc;
    assign imem_addr  = pc;
    assign halted     = (state == ST_HALT);
    assign fault      = (state == ST_FAULT);

    p_halt_hold_r7: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted && $stable(imem_addr));

    p_fault_hold_r6: assert property (@(posedge clk) disable iff (rst)
        fault |=> fault && !dmem_we && $stable(imem_addr));

    p_store_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        dmem_we |=> !dmem_we);

    p_exd_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (in_exec && dec.op == OPC_EXD) |=> (state == ST_EXEC) && $stable(pc));

    p_seq_pc_r8: assert property (@(posedge clk) disable iff (rst)
        (in_exec && is_seq) |=> (state == ST_FETCH) && (pc == $past(pc) + ADDR_W'(1)));

    p_branch_pc_r5: assert property (@(posedge clk) disable iff (rst)
        (in_exec && take_branch) |=> (pc == $past(dec.addr)));

    p_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(halted && fault));
endmodule

// File: tb/acc_core_tb.sv
module acc_core_tb;
    import acc_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] imem_addr;
    logic [WORD_W-1:0] imem_data;
    logic [ADDR_W-1:0] dmem_addr;
    logic              dmem_we;
    logic [WORD_W-1:0] dmem_wdata;
    logic [WORD_W-1:0] dmem_rdata;
    logic              halted;
    logic              fault;

    logic [WORD_W-1:0] imem [1024];
    logic [WORD_W-1:0] dmem [1024];
    logic              tb_we = 1'b0;
    logic [ADDR_W-1:0] tb_addr = '0;
    logic [WORD_W-1:0] tb_wd = '0;

    int checks = 0;
    int fails  = 0;
    int wd_cnt = 0;

    always #2 clk = ~clk;

    acc_core u_dut (
        .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
        .dmem_addr(dmem_addr), .dmem_we(dmem_we), .dmem_wdata(dmem_wdata),
        .dmem_rdata(dmem_rdata), .halted(halted), .fault(fault)
    );

    assign imem_data = imem[imem_addr];

    always @(posedge clk) begin
        if (tb_we) dmem[tb_addr] <= tb_wd;
        else if (dmem_we) dmem[dmem_addr] <= dmem_wdata;
        dmem_rdata <= dmem[dmem_addr];
    end

    always @(posedge clk) begin
        wd_cnt++;
        if (wd_cnt > 150000) begin
            fails++;
            $display("FAIL R8 watchdog expired: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [WORD_W-1:0] w(input logic [OP_W-1:0] op, input int a);
        return make_word(op, ADDR_W'(a));
    endfunction

    task automatic dput(input int a, input logic [WORD_W-1:0] v);
        @(negedge clk);
        tb_we = 1'b1; tb_addr = ADDR_W'(a); tb_wd = v;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic hold_reset();
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 32; i++) imem[i] = w(OPC_HLT, 0);
    endtask

    task automatic release_reset();
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run(input int lim, output int cyc);
        cyc = 0;
        while (!halted && !fault && cyc < lim) begin
            @(posedge clk);
            @(negedge clk);
            cyc++;
        end
    endtask

    int cyc;
    logic [WORD_W-1:0] a, b, v, exp_sum;

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 1024; i++) begin imem[i] = '0; dmem[i] = '0; end

        // R10 reset state
        hold_reset();
        repeat (3) @(negedge clk);
        chk(!halted && !fault && !dmem_we, "R10", "flags in reset", {halted, fault, dmem_we}, 0);
        chk(imem_addr == 0, "R10", "pc in reset", imem_addr, 0);

        // R4 R1 R8: EXD on 0x0406 (ADD 6) adds Mem[6]
        hold_reset();
        imem[0] = w(OPC_LD, 70); imem[1] = w(OPC_EXD, 0);
        imem[2] = w(OPC_STORE, 60); imem[3] = w(OPC_HLT, 0);
        dput(70, 16'h0406); dput(6, 16'h0001); dput(60, 16'hBEEF);
        release_reset();
        run(100, cyc);
        chk(dmem[60] == 16'h0407, "R4", "EXD of ADD 6", dmem[60], 16'h0407);
        chk(cyc == 9, "R8", "cycles LD+EXD+STORE+HLT", cyc, 9);
        chk(halted && imem_addr == 3, "R7", "halt pc", imem_addr, 3);
        repeat (10) @(negedge clk);
        chk(halted && !fault && imem_addr == 3, "R7", "halt sticky", imem_addr, 3);

        // R2 arithmetic, random
        for (int t = 0; t < 6; t++) begin
            a = 16'($urandom); b = 16'($urandom);
            if (t == 0) begin a = 16'h0000; b = 16'h0001; end
            if (t == 1) begin a = 16'hFFFF; b = 16'hFFFF; end
            hold_reset();
            imem[0] = w(OPC_LD, 90);  imem[1] = w(OPC_SUB, 91); imem[2] = w(OPC_STORE, 92);
            imem[3] = w(OPC_CLEAR, 0); imem[4] = w(OPC_ADD, 91); imem[5] = w(OPC_STORE, 93);
            imem[6] = w(OPC_LD, 91);  imem[7] = w(OPC_ADD, 90); imem[8] = w(OPC_STORE, 94);
            imem[9] = w(OPC_HLT, 0);
            dput(90, a); dput(91, b);
            release_reset();
            run(200, cyc);
            chk(dmem[92] == 16'(a - b), "R2", "SUB wrap", dmem[92], 16'(a - b));
            chk(dmem[93] == b, "R2", "CLEAR then ADD", dmem[93], b);
            chk(dmem[94] == 16'(a + b), "R2", "ADD wrap", dmem[94], 16'(a + b));
            chk(cyc == 20, "R8", "cycles 10 instr", cyc, 20);
        end

        // R5 branches, random and directed signs
        for (int t = 0; t < 10; t++) begin
            bit use_bge;
            bit jump;
            v = 16'($urandom);
            if (t == 0) v = 16'h8000;
            if (t == 1) v = 16'h7FFF;
            if (t == 2) v = 16'h0000;
            if (v == 16'hBEEF) v = 16'h1234;
            use_bge = t[0];
            jump = use_bge ? !v[15] : v[15];
            hold_reset();
            imem[0] = w(OPC_LD, 80);
            imem[1] = w(use_bge ? OPC_BGE : OPC_BLT, 4);
            imem[2] = w(OPC_STORE, 81); imem[3] = w(OPC_HLT, 0);
            imem[4] = w(OPC_STORE, 82); imem[5] = w(OPC_HLT, 0);
            dput(80, v); dput(81, 16'hBEEF); dput(82, 16'hBEEF);
            release_reset();
            run(100, cyc);
            if (jump) begin
                chk(dmem[82] == v && dmem[81] == 16'hBEEF, "R5", "taken branch store", dmem[82], v);
                chk(imem_addr == 5, "R5", "taken pc", imem_addr, 5);
            end else begin
                chk(dmem[81] == v && dmem[82] == 16'hBEEF, "R5", "fallthrough store", dmem[81], v);
                chk(imem_addr == 3, "R5", "fallthrough pc", imem_addr, 3);
            end
        end

        // R4 EXD of a taken BGE moves PC to the target
        hold_reset();
        imem[0] = w(OPC_LD, 71); imem[1] = w(OPC_EXD, 0);
        imem[2] = w(OPC_STORE, 61); imem[6] = w(OPC_HLT, 0);
        dput(71, w(OPC_BGE, 6)); dput(61, 16'hBEEF);
        release_reset();
        run(100, cyc);
        chk(halted && imem_addr == 6, "R4", "EXD branch target", imem_addr, 6);
        chk(dmem[61] == 16'hBEEF, "R4", "skipped store", dmem[61], 16'hBEEF);

        // R9 EXD of EXD never ends
        hold_reset();
        imem[0] = w(OPC_LD, 72); imem[1] = w(OPC_EXD, 0); imem[2] = w(OPC_HLT, 0);
        dput(72, w(OPC_EXD, 0));
        release_reset();
        run(300, cyc);
        chk(!halted && !fault, "R9", "no stop in EXD loop", {halted, fault}, 0);
        chk(imem_addr == 1, "R9", "pc held in EXD loop", imem_addr, 1);

        // R6 illegal fetched opcode
        hold_reset();
        imem[0] = 16'hFC00; imem[1] = w(OPC_STORE, 63);
        dput(63, 16'hBEEF);
        release_reset();
        run(100, cyc);
        repeat (20) @(negedge clk);
        chk(fault && !halted, "R6", "fault on fetched illegal", {fault, halted}, 2);
        chk(imem_addr == 0 && dmem[63] == 16'hBEEF, "R6", "frozen after fault", dmem[63], 16'hBEEF);

        // R6 R1 illegal opcode reached through EXD (opcode 8 unused)
        hold_reset();
        imem[0] = w(OPC_LD, 73); imem[1] = w(OPC_EXD, 0);
        imem[2] = w(OPC_STORE, 64); imem[3] = w(OPC_HLT, 0);
        dput(73, 16'h2000); dput(64, 16'hBEEF);
        release_reset();
        run(100, cyc);
        repeat (20) @(negedge clk);
        chk(fault && imem_addr == 1, "R6", "fault via EXD", imem_addr, 1);
        chk(dmem[64] == 16'hBEEF, "R6", "no store after EXD fault", dmem[64], 16'hBEEF);

        // R4 R3 pointer-table sum through EXD-built loads
        for (int run_i = 0; run_i < 2; run_i++) begin
            int n;
            n = (run_i == 0) ? 10 : 5;
            hold_reset();
            imem[0]  = w(OPC_LD, 50);    imem[1]  = w(OPC_SUB, 51);   imem[2]  = w(OPC_BLT, 15);
            imem[3]  = w(OPC_STORE, 50); imem[4]  = w(OPC_LD, 53);    imem[5]  = w(OPC_EXD, 0);
            imem[6]  = w(OPC_ADD, 52);   imem[7]  = w(OPC_EXD, 0);    imem[8]  = w(OPC_ADD, 54);
            imem[9]  = w(OPC_STORE, 54); imem[10] = w(OPC_LD, 53);    imem[11] = w(OPC_ADD, 51);
            imem[12] = w(OPC_STORE, 53); imem[13] = w(OPC_CLEAR, 0);  imem[14] = w(OPC_BGE, 0);
            imem[15] = w(OPC_HLT, 0);
            dput(50, 16'(n)); dput(51, 16'h0001); dput(52, w(OPC_LD, 0));
            dput(53, w(OPC_LD, 100)); dput(54, 16'h0000);
            exp_sum = '0;
            for (int i = 0; i < n; i++) begin
                int p;
                p = 200 + int'($urandom % 100);
                v = 16'($urandom);
                dput(100 + i, 16'(p));
                dput(p, v);
                exp_sum = dmem[p] + exp_sum - dmem[p] + v;
                exp_sum = exp_sum;
            end
            exp_sum = '0;
            for (int i = 0; i < n; i++) exp_sum = exp_sum + dmem[dmem[100 + i][ADDR_W-1:0]];
            release_reset();
            run(2000, cyc);
            chk(dmem[54] == exp_sum, "R4", "pointer sum", dmem[54], exp_sum);
            chk(cyc == 32 * n + 8, "R8", "pointer loop cycles", cyc, 32 * n + 8);
            chk(dmem[50] == 0, "R3", "counter stored", dmem[50], 0);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule